// File: doc/BRIEF.md
# Ethernet Command Frame Bus Decoder

This block takes raw Ethernet frames as a byte stream, one byte per accepted cycle, with a start-of-frame flag on the first byte and an end-of-frame flag on the last. It first screens the frame header. If the frame is for this station, it executes the bus commands that follow the header, one at a time and in order, on a simple request/ready bus-master port. The station's unicast address comes in as a static input. Broadcast frames are also accepted. Frames addressed anywhere else are swallowed with no side effect.

Each frame starts with an 18-byte preamble. The first 14 bytes are the ordinary Ethernet header. The last 4 bytes carry a reserved half-word and then the number of commands in the frame. After the preamble comes a packed list of commands of different lengths:
- A write issues one bus write.
- A read issues one bus read.
- A delay holds off every later command for a given number of clock cycles.

While a request is outstanding or a delay is running, the block stalls the byte stream through `in_ready_o`, so it needs no frame buffer. Frames of any length, jumbo frames included, pass through. A frame that is cut short, or that carries an unknown command code, raises a sticky error flag and stops decoding of that frame.

Top module: `pkt_cmd_decoder`

## Requirements
- R1: After reset, `bus_valid_o` is 0, `in_ready_o` is 1 and `err_o` is 0.
- R2: The 18-byte preamble is laid out as follows, with the command count big-endian:
  - bytes 0-5: destination address;
  - bytes 6-11: source address;
  - bytes 12-13: length;
  - bytes 14-15: reserved;
  - bytes 16-17: command count.
  A frame is decoded only when its destination equals `mac_i` (byte 0 compared with `mac_i[47:40]`) or is all ones. For any other destination, no bus request is made and `err_o` stays 0.
- R3: A write command is control 0x0001, then a 4-byte address, then 2 bytes of data, all big-endian. It produces one request with `bus_op_o`=0 and that address and data.
- R4: A read command is control 0x0002 followed by a 4-byte big-endian address. It produces one request with `bus_op_o`=1, that address and `bus_wdata_o`=0.
- R5: A delay command is control 0x0003 followed by a 2-byte big-endian cycle count N. It lengthens the gap between the requests on either side of it by exactly N cycles compared with N=0.
- R6: Commands are issued in frame order, and exactly as many as the count says. Bytes after the last counted command are ignored up to end-of-frame.
- R7: While `bus_valid_o` is high and `bus_ready_i` is low, the request fields hold steady. `in_ready_o` is low whenever a request is pending.
- R8: If the frame ends before the counted commands are complete, `err_o` is set. The commands completed before the end are still issued, and a partial command is not.
- R9: A control word other than 0x0001 to 0x0003 sets `err_o`. Neither that command nor any later command in the frame is issued.
- R10: `err_o` stays set until the first byte of the next frame is accepted, and that byte clears it.
- R11: A frame with a command count of 0 issues nothing and leaves `err_o` at 0.
- R12: There is no frame length limit. A 8994-byte frame carrying 1122 writes issues all 1122 of them in order.
- R13: A frame that ends inside the 18-byte preamble is dropped without a request and without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mac_i | input | 48 | Station unicast address |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_sof_i | input | 1 | First byte of frame |
| in_eof_i | input | 1 | Last byte of frame |
| in_ready_o | output | 1 | Stream byte accepted when high with valid |
| bus_valid_o | output | 1 | Bus request pending |
| bus_ready_i | input | 1 | Bus request taken |
| bus_op_o | output | 1 | 0 write, 1 read |
| bus_addr_o | output | ADDR_W | Request address |
| bus_wdata_o | output | DATA_W | Write data |
| err_o | output | 1 | Sticky frame decode error |

## Verification
The hardest situation to reach is a frame that ends on the very byte that completes a command while the count is still unmet. In that case the last command must still go out, and only then may the error flag rise. The stimulus builds that frame directly: a three-command count with a single complete write and end-of-frame on the write's final data byte. A second frame does the same with a half-written command, so both paths are covered. Delay timing is checked by difference. The same write, delay, write frame is replayed with several wait values, and the spacing between the two issued writes is compared, so no absolute pipeline latency has to be assumed.

// File: rtl/pkt_cmd_pkg.sv
package pkt_cmd_pkg;
  localparam int MAC_B   = 6;
  localparam int MAC_W   = 8 * MAC_B;
  localparam int HDR_B   = 18;
  localparam int CNT_POS = 16;
  localparam int CNT_W   = 16;
  localparam int CTRL_B  = 2;

  localparam logic [15:0] CTRL_WR  = 16'h0001;
  localparam logic [15:0] CTRL_RD  = 16'h0002;
  localparam logic [15:0] CTRL_DLY = 16'h0003;

  typedef enum logic [1:0] {K_NONE, K_WR, K_RD, K_DLY} cmd_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_CMD, ST_ISSUE, ST_WAIT, ST_SKIP} dec_state_e;
endpackage

// File: rtl/pkt_hdr_filter.sv
module pkt_hdr_filter
  import pkt_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             first_i,
  input  logic             byte_en_i,
  input  logic [7:0]       data_i,
  input  logic [MAC_W-1:0] mac_i,
  output logic             last_o,
  output logic             pass_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int IDX_W = $clog2(HDR_B + 1);

  logic [IDX_W-1:0] idx_q;
  logic             uc_q, bc_q;
  logic [7:0]       cnt_hi_q;
  logic [7:0]       mac_byte;

  always_comb begin
    mac_byte = '0;
    for (int b = 0; b < MAC_B; b++) begin
      if (idx_q == IDX_W'(b)) mac_byte = mac_i[8*(MAC_B-1-b) +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      uc_q     <= 1'b0;
      bc_q     <= 1'b0;
      cnt_hi_q <= '0;
    end else if (first_i) begin
      idx_q <= IDX_W'(1);
      uc_q  <= (data_i == mac_i[MAC_W-1 -: 8]);
      bc_q  <= (data_i == 8'hFF);
    end else if (byte_en_i) begin
      idx_q <= idx_q + IDX_W'(1);
      if (idx_q < IDX_W'(MAC_B)) begin
        uc_q <= uc_q && (data_i == mac_byte);
        bc_q <= bc_q && (data_i == 8'hFF);
      end
      if (idx_q == IDX_W'(CNT_POS)) cnt_hi_q <= data_i;
    end
  end

  assign last_o  = byte_en_i && (idx_q == IDX_W'(HDR_B - 1));
  assign pass_o  = uc_q || bc_q;
  assign count_o = {cnt_hi_q, data_i};

  AST_HDR_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_en_i |-> (idx_q != '0) && (idx_q < IDX_W'(HDR_B))); // R13
endmodule

// File: rtl/pkt_cmd_asm.sv
module pkt_cmd_asm
  import pkt_cmd_pkg::*;
#(
  parameter int ADDR_B = 4,
  parameter int DATA_B = 2,
  parameter int DLY_B  = 2,
  localparam int BODY_B = (ADDR_B + DATA_B > DLY_B) ? (ADDR_B + DATA_B) : DLY_B,
  localparam int BODY_W = 8 * BODY_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [7:0]        data_i,
  output logic              bad_o,
  output logic              done_o,
  output cmd_kind_e         kind_o,
  output logic [BODY_W-1:0] body_o
);
  localparam int IDX_W = $clog2(CTRL_B + BODY_B + 1);
  localparam logic [IDX_W-1:0] LAST_WR  = IDX_W'(CTRL_B + ADDR_B + DATA_B - 1);
  localparam logic [IDX_W-1:0] LAST_RD  = IDX_W'(CTRL_B + ADDR_B - 1);
  localparam logic [IDX_W-1:0] LAST_DLY = IDX_W'(CTRL_B + DLY_B - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        ctrl_hi_q;
  cmd_kind_e         kind_q, kind_dec;
  logic [BODY_W-1:0] body_q;
  logic [IDX_W-1:0]  last_idx;

  always_comb begin
    unique case ({ctrl_hi_q, data_i})
      CTRL_WR:  kind_dec = K_WR;
      CTRL_RD:  kind_dec = K_RD;
      CTRL_DLY: kind_dec = K_DLY;
      default:  kind_dec = K_NONE;
    endcase
  end

  always_comb begin
    unique case (kind_q)
      K_WR:    last_idx = LAST_WR;
      K_RD:    last_idx = LAST_RD;
      K_DLY:   last_idx = LAST_DLY;
      default: last_idx = '0;
    endcase
  end

  assign bad_o  = en_i && (idx_q == IDX_W'(1)) && (kind_dec == K_NONE);
  assign done_o = en_i && (idx_q > IDX_W'(1)) && (idx_q == last_idx);
  assign kind_o = kind_q;
  assign body_o = {body_q[BODY_W-9:0], data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      ctrl_hi_q <= '0;
      kind_q    <= K_NONE;
      body_q    <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (en_i) begin
      idx_q <= (bad_o || done_o) ? '0 : idx_q + IDX_W'(1);
      if (idx_q == '0) ctrl_hi_q <= data_i;
      if (idx_q == IDX_W'(1)) kind_q <= kind_dec;
      if (idx_q > IDX_W'(1)) body_q <= {body_q[BODY_W-9:0], data_i};
    end
  end

  AST_KIND_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && idx_q > IDX_W'(1)) |-> (kind_q != K_NONE)); // R9
endmodule

// File: rtl/pkt_delay_timer.sv
module pkt_delay_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] val_i,
  output logic             last_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - DLY_W'(1);
  end

  assign last_o = (cnt_q == DLY_W'(1));

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - DLY_W'(1))); // R5
  AST_TMR_IDLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == '0) && (val_i != '0)); // R5
endmodule

// File: rtl/pkt_cmd_decoder.sv
module pkt_cmd_decoder
  import pkt_cmd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [47:0]       mac_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  output logic              in_ready_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic              bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              err_o
);
  localparam int ADDR_B = ADDR_W / 8;
  localparam int DATA_B = DATA_W / 8;
  localparam int DLY_B  = DLY_W / 8;
  localparam int BODY_B = (ADDR_B + DATA_B > DLY_B) ? (ADDR_B + DATA_B) : DLY_B;
  localparam int BODY_W = 8 * BODY_B;

  dec_state_e        state_q, state_d;
  logic              err_q, err_d;
  logic              eof_q, eof_d;
  logic              drop_q, drop_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic acc, hdr_first, hdr_en, hdr_last, hdr_pass;
  logic [CNT_W-1:0] hdr_count;
  logic cmd_en, cmd_bad, cmd_done;
  cmd_kind_e cmd_kind;
  logic [BODY_W-1:0] body;
  logic [DLY_W-1:0]  dly_val;
  logic tmr_load, tmr_last, cap, fin, fin_eof;

  assign in_ready_o = (state_q != ST_ISSUE) && (state_q != ST_WAIT);
  assign acc        = in_valid_i && in_ready_o;
  assign hdr_first  = (state_q == ST_IDLE) && acc && in_sof_i;
  assign hdr_en     = (state_q == ST_HDR) && acc;
  assign cmd_en     = (state_q == ST_CMD) && acc;
  assign dly_val    = body[DLY_W-1:0];

  pkt_hdr_filter u_hdr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_i  (hdr_first),
    .byte_en_i(hdr_en),
    .data_i   (in_data_i),
    .mac_i    (mac_i),
    .last_o   (hdr_last),
    .pass_o   (hdr_pass),
    .count_o  (hdr_count)
  );

  pkt_cmd_asm #(
    .ADDR_B(ADDR_B),
    .DATA_B(DATA_B),
    .DLY_B (DLY_B)
  ) u_asm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (hdr_first),
    .en_i  (cmd_en),
    .data_i(in_data_i),
    .bad_o (cmd_bad),
    .done_o(cmd_done),
    .kind_o(cmd_kind),
    .body_o(body)
  );

  pkt_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (dly_val),
    .last_o(tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    eof_d    = eof_q;
    drop_d   = drop_q;
    rem_d    = rem_q;
    cap      = 1'b0;
    tmr_load = 1'b0;
    fin      = 1'b0;
    fin_eof  = eof_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hdr_first) begin
          err_d   = 1'b0;
          drop_d  = 1'b0;
          state_d = in_eof_i ? ST_IDLE : ST_HDR;
        end
      end
      ST_HDR: begin
        if (acc) begin
          if (hdr_last) begin
            if (!hdr_pass) begin
              drop_d  = 1'b1;
              state_d = in_eof_i ? ST_IDLE : ST_SKIP;
            end else if (hdr_count == '0) begin
              state_d = in_eof_i ? ST_IDLE : ST_SKIP;
            end else begin
              rem_d = hdr_count;
              if (in_eof_i) begin
                err_d   = 1'b1;
                state_d = ST_IDLE;
              end else begin
                state_d = ST_CMD;
              end
            end
          end else if (in_eof_i) begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_CMD: begin
        if (acc) begin
          if (cmd_bad) begin
            err_d   = 1'b1;
            state_d = in_eof_i ? ST_IDLE : ST_SKIP;
          end else if (cmd_done) begin
            eof_d = in_eof_i;
            if (cmd_kind == K_DLY) begin
              if (dly_val != '0) begin
                tmr_load = 1'b1;
                state_d  = ST_WAIT;
              end else begin
                fin     = 1'b1;
                fin_eof = in_eof_i;
              end
            end else begin
              cap     = 1'b1;
              state_d = ST_ISSUE;
            end
          end else if (in_eof_i) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_ISSUE: if (bus_ready_i) fin = 1'b1;
      ST_WAIT:  if (tmr_last) fin = 1'b1;
      ST_SKIP:  if (acc && in_eof_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (fin) begin
      rem_d = rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) begin
        state_d = fin_eof ? ST_IDLE : ST_SKIP;
      end else if (fin_eof) begin
        err_d   = 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = ST_CMD;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      eof_q   <= 1'b0;
      drop_q  <= 1'b0;
      rem_q   <= '0;
      op_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      eof_q   <= eof_d;
      drop_q  <= drop_d;
      rem_q   <= rem_d;
      if (cap) begin
        op_q <= (cmd_kind == K_RD);
        if (cmd_kind == K_WR) begin
          addr_q <= body[ADDR_W+DATA_W-1:DATA_W];
          data_q <= body[DATA_W-1:0];
        end else begin
          addr_q <= body[ADDR_W-1:0];
          data_q <= '0;
        end
      end
    end
  end

  assign bus_valid_o = (state_q == ST_ISSUE);
  assign bus_op_o    = op_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = data_q;
  assign err_o       = err_q;

  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=> bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_wdata_o) && $stable(bus_op_o)); // R7
  AST_REM_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_CMD, ST_ISSUE, ST_WAIT}) |-> (rem_q != '0)); // R6
  AST_DROP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q |-> !bus_valid_o && (state_q inside {ST_IDLE, ST_SKIP})); // R2
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !hdr_first) |=> err_o); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_first |=> !err_o); // R10
endmodule

// File: tb/pkt_cmd_decoder_tb.sv
module pkt_cmd_decoder_tb;
  localparam logic [47:0] MAC   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic bus_ready = 1'b1;
  logic in_ready, bus_valid, bus_op, err;
  logic [31:0] bus_addr;
  logic [15:0] bus_wdata;

  int checks = 0, fails = 0, cyc = 0;
  int viol = 0;
  bit rdy_slow = 0;

  logic [7:0] frm [0:9215];
  int flen = 0;

  logic [31:0] log_addr [0:2047];
  logic [15:0] log_data [0:2047];
  logic        log_op   [0:2047];
  int          log_t    [0:2047];
  int nlog = 0;

  logic pend = 0;
  logic [31:0] p_addr;
  logic [15:0] p_data;
  logic p_op;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pkt_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mac_i(MAC),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .in_ready_o(in_ready), .bus_valid_o(bus_valid), .bus_ready_i(bus_ready),
    .bus_op_o(bus_op), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .err_o(err)
  );

  // bus side: drive ready, log handshakes, watch hold rules (R7)
  always @(negedge clk) begin
    bus_ready = rdy_slow ? ((cyc % 3) == 2) : 1'b1;
    if (bus_valid) begin
      if (in_ready) viol++;
      if (pend && (bus_addr !== p_addr || bus_wdata !== p_data || bus_op !== p_op)) viol++;
      if (bus_ready) begin
        if (nlog < 2048) begin
          log_addr[nlog] = bus_addr;
          log_data[nlog] = bus_wdata;
          log_op[nlog]   = bus_op;
          log_t[nlog]    = cyc;
        end
        nlog++;
        pend = 0;
      end else begin
        pend = 1; p_addr = bus_addr; p_data = bus_wdata; p_op = bus_op;
      end
    end else begin
      pend = 0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_b(input logic [7:0] b);
    frm[flen] = b; flen++;
  endtask

  task automatic begin_frame(input logic [47:0] dst, input logic [15:0] cnt);
    flen = 0;
    for (int i = 5; i >= 0; i--) put_b(dst[8*i +: 8]);
    for (int i = 0; i < 6; i++) put_b(8'hA0 + 8'(i));
    put_b(8'h00); put_b(8'h40);
    put_b(8'h00); put_b(8'h00);
    put_b(cnt[15:8]); put_b(cnt[7:0]);
  endtask

  task automatic add_wr(input logic [31:0] a, input logic [15:0] d);
    put_b(8'h00); put_b(8'h01);
    for (int i = 3; i >= 0; i--) put_b(a[8*i +: 8]);
    put_b(d[15:8]); put_b(d[7:0]);
  endtask

  task automatic add_rd(input logic [31:0] a);
    put_b(8'h00); put_b(8'h02);
    for (int i = 3; i >= 0; i--) put_b(a[8*i +: 8]);
  endtask

  task automatic add_dly(input logic [15:0] v);
    put_b(8'h00); put_b(8'h03); put_b(v[15:8]); put_b(v[7:0]);
  endtask

  task automatic send_frame();
    int i = 0;
    while (i < flen) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = frm[i];
      in_sof = (i == 0); in_eof = (i == flen - 1);
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run(input int settle);
    nlog = 0;
    send_frame();
    repeat (settle) @(negedge clk);
  endtask

  task automatic t_reset();
    check(bus_valid == 1'b0, "R1 bus_valid", bus_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(err == 1'b0, "R1 err", err, 0);
  endtask

  task automatic t_mixed_slow();
    rdy_slow = 1;
    begin_frame(MAC, 3);
    add_wr(32'h1234_5678, 16'hBEEF);
    add_rd(32'hCAFE_0010);
    add_wr(32'h0000_00FC, 16'h0102);
    run(30);
    rdy_slow = 0;
    check(nlog == 3, "R6 count", nlog, 3);
    check(log_op[0] == 1'b0 && log_addr[0] == 32'h1234_5678 && log_data[0] == 16'hBEEF,
          "R3 write fields", {log_op[0], log_addr[0], log_data[0]}, {1'b0, 32'h1234_5678, 16'hBEEF});
    check(log_op[1] == 1'b1 && log_addr[1] == 32'hCAFE_0010 && log_data[1] == 16'h0,
          "R4 read fields", {log_op[1], log_addr[1], log_data[1]}, {1'b1, 32'hCAFE_0010, 16'h0});
    check(log_addr[2] == 32'h0000_00FC && log_data[2] == 16'h0102,
          "R6 order", {log_addr[2], log_data[2]}, {32'h0000_00FC, 16'h0102});
    check(err == 1'b0, "R3 no error", err, 0);
    check(viol == 0, "R7 hold and stall", viol, 0);
  endtask

  task automatic t_bcast();
    begin_frame(BCAST, 1);
    add_wr(32'h0000_0200, 16'h7777);
    run(10);
    check(nlog == 1 && log_addr[0] == 32'h200, "R2 broadcast accepted", nlog, 1);
  endtask

  task automatic t_drop();
    begin_frame(OTHER, 2);
    add_wr(32'h0000_0300, 16'h1111);
    add_rd(32'h0000_0304);
    run(10);
    check(nlog == 0, "R2 foreign dropped", nlog, 0);
    check(err == 1'b0, "R2 no error on drop", err, 0);
    check(in_ready == 1'b1, "R2 back to idle", in_ready, 1);
  endtask

  task automatic t_extra();
    begin_frame(MAC, 2);
    add_wr(32'h10, 16'h1);
    add_wr(32'h14, 16'h2);
    add_wr(32'h18, 16'h3);
    run(10);
    check(nlog == 2, "R6 count limits issue", nlog, 2);
    check(err == 1'b0, "R6 trailing bytes ignored", err, 0);
  endtask

  task automatic t_delay();
    int base = 0;
    for (int k = 0; k < 3; k++) begin
      logic [15:0] d;
      d = (k == 0) ? 16'd0 : (k == 1) ? 16'd1 : 16'd7;
      begin_frame(MAC, 3);
      add_wr(32'h100, 16'hAAAA);
      add_dly(d);
      add_wr(32'h104, 16'hBBBB);
      run(15);
      if (k == 0) base = log_t[1] - log_t[0];
      else check(nlog == 2 && (log_t[1] - log_t[0]) - base == int'(d),
                 "R5 delay gap", (log_t[1] - log_t[0]) - base, d);
    end
  endtask

  task automatic t_trunc();
    begin_frame(MAC, 3);
    add_wr(32'h20, 16'h2020);
    run(10);
    check(nlog == 1, "R8 completed cmd issued", nlog, 1);
    check(err == 1'b1, "R8 short count error", err, 1);
    begin_frame(MAC, 2);
    add_wr(32'h24, 16'h2424);
    put_b(8'h00); put_b(8'h01); put_b(8'h12); put_b(8'h34);
    run(10);
    check(nlog == 1, "R8 partial cmd not issued", nlog, 1);
    check(err == 1'b1, "R8 mid-command error", err, 1);
  endtask

  task automatic t_badctrl();
    begin_frame(MAC, 3);
    add_wr(32'h30, 16'h3030);
    put_b(8'h00); put_b(8'h07); put_b(8'h00); put_b(8'h00);
    add_wr(32'h34, 16'h3434);
    run(10);
    check(nlog == 1, "R9 stop at bad control", nlog, 1);
    check(err == 1'b1, "R9 error set", err, 1);
  endtask

  task automatic t_err_clear();
    repeat (5) @(negedge clk);
    check(err == 1'b1, "R10 error held", err, 1);
    begin_frame(MAC, 1);
    add_rd(32'h40);
    run(10);
    check(err == 1'b0, "R10 error cleared", err, 0);
    check(nlog == 1, "R10 next frame decoded", nlog, 1);
  endtask

  task automatic t_zero();
    begin_frame(MAC, 0);
    add_wr(32'h50, 16'h5);
    run(10);
    check(nlog == 0 && err == 1'b0, "R11 zero count", nlog, 0);
  endtask

  task automatic t_short();
    begin_frame(MAC, 1);
    flen = 10;
    run(10);
    check(nlog == 0 && err == 1'b0, "R13 truncated header", {nlog[7:0], err}, 0);
  endtask

  task automatic t_jumbo();
    int bad = 0;
    begin_frame(MAC, 16'd1122);
    for (int i = 0; i < 1122; i++) add_wr(32'(i * 4), 16'(i) ^ 16'hA5A5);
    check(flen == 8994, "R12 frame length", flen, 8994);
    run(10);
    check(nlog == 1122, "R12 jumbo count", nlog, 1122);
    for (int i = 0; i < 1122 && i < nlog; i++)
      if (log_addr[i] != 32'(i * 4) || log_data[i] != (16'(i) ^ 16'hA5A5)) bad++;
    check(bad == 0, "R12 jumbo content", bad, 0);
    check(err == 1'b0, "R12 no error", err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed_slow();
    t_bcast();
    t_drop();
    t_extra();
    t_delay();
    t_trunc();
    t_badctrl();
    t_err_clear();
    t_zero();
    t_short();
    t_jumbo();
    check(viol == 0, "R7 final hold check", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule